// File: doc/BRIEF.md
# Real-Time Clock Calendar Register Core

This block keeps the time of day and the calendar date for a PC-style battery-backed real-time clock. It holds seven counters: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-second strobe enters on `sec_tick`. On each strobe the counters advance as a carry chain, from seconds up to year. A control register selects BCD or binary coding and 12-hour or 24-hour display. In 12-hour display the top bit of the hour register is the PM flag.

A host reaches the registers through two byte ports. It first writes a register index to the index port, then reads or writes the selected register through the data port. Read data is registered and appears one cycle after the read strobe. To set the clock, the host sets the freeze bit, writes the new values, and then clears the freeze bit. The freeze bit stops the advance while the host writes. A status register reports whether the supply input has stayed good since that register was last read.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset the time fields read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, day of month 0x01, month 0x01 and year 0x00. The control register (index 11) reads 0x02 and the status register (index 13) reads 0x80.
- R2: A write with `bus_sel_data`=0 loads the low 7 bits of `bus_wdata` as the register index, and bit 7 is ignored. A write with `bus_sel_data`=1 stores into the indexed register. A read with `bus_sel_data`=1 returns the indexed register on `bus_rdata` one cycle later, and `bus_rdata` holds its value between reads.
- R3: The time fields sit at indices 0 (seconds), 2 (minutes), 4 (hours), 6 (weekday), 7 (day of month), 8 (month) and 9 (year). Seconds and minutes wrap from 59 to 0 and carry into the next field. In 24-hour mode the hour wraps from 23 to 0 and carries into the date. With no tick and no data write, the fields do not change.
- R4: Control bit 2 selects the number coding: 0 means BCD and 1 means binary. Seconds 0x09 step to 0x10 in BCD and to 0x0A in binary.
- R5: Control bit 1 selects the hour format: 0 means 12-hour and 1 means 24-hour. In 12-hour mode the hour runs from 1 to 12 and hour bit 7 is PM. Hour 11 steps to 12 and toggles PM. Hour 12 steps to 1 and keeps PM. The step from 11 PM to 12 AM carries into the date. In BCD, 0x11 goes to 0x92, 0x92 goes to 0x81, and 0x91 goes to 0x12.
- R6: On a day carry the weekday steps 1 to 7 and then wraps from 7 back to 1, where 1 means Sunday.
- R7: On a day carry the day of month wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11, 31 for the other months, and for month 2 either 28, or 29 when the year is divisible by 4. This wrap carries into the month. The month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0.
- R8: While control bit 7 is 1, ticks change no time field. After the bit is cleared, ticks advance the fields again.
- R9: Indices other than 0, 2, 4, 6, 7, 8, 9, 11 and 13 read as 0x00. Writes to those indices have no effect.
- R10: Status bit 7 at index 13 is cleared while `supply_ok` is low. A read of index 13 returns the flag and then sets it again if `supply_ok` is high. Writes to index 13 have no effect.
- R11: The control register keeps only bits 7, 2 and 1. Its other bits read as 0.
- R12: When a data write to a time field happens in the same cycle as a tick, the written value is stored in that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| supply_ok | input | 1 | High while the clock supply is good |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_sel_data | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The advance is exercised with start values that stop the carry chain at different fields: a seconds-only step, a carry that stops at minutes or hours, and full day, month and year rollovers. Each start value shows a separate wrap limit. The same seconds step is run in BCD and in binary, so an error in the decimal adjust cannot hide. The hour is walked through 11 AM, 12 PM and 11 PM in 12-hour mode, which separates the PM toggle from the date carry. February is tried with year 23 and year 24 to show the leap-year decision, alongside a 30-day month and a 31-day month.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_DW = 8;

  localparam int IDX_SEC   = 0;
  localparam int IDX_MIN   = 2;
  localparam int IDX_HOUR  = 4;
  localparam int IDX_WDAY  = 6;
  localparam int IDX_MDAY  = 7;
  localparam int IDX_MON   = 8;
  localparam int IDX_YEAR  = 9;
  localparam int IDX_CTRL  = 11;
  localparam int IDX_STAT  = 13;

  // control bit positions
  localparam int CTRL_FREEZE = 7;
  localparam int CTRL_BIN    = 2;
  localparam int CTRL_H24    = 1;
  localparam logic [RTC_DW-1:0] CTRL_MASK  = 8'h86;
  localparam logic [RTC_DW-1:0] CTRL_RESET = 8'h02;

  typedef struct packed {
    logic [RTC_DW-1:0] sec;
    logic [RTC_DW-1:0] minute;
    logic [RTC_DW-1:0] hour;
    logic [RTC_DW-1:0] wday;
    logic [RTC_DW-1:0] mday;
    logic [RTC_DW-1:0] mon;
    logic [RTC_DW-1:0] year;
  } rtc_time_t;

  localparam rtc_time_t TIME_RESET = '{
    sec: 8'h00, minute: 8'h00, hour: 8'h00,
    wday: 8'h01, mday: 8'h01, mon: 8'h01, year: 8'h00};

  // register coding -> plain count
  function automatic logic [6:0] to_bin(input logic [7:0] v, input logic bcd);
    logic [6:0] hi;
    hi = {3'b000, v[7:4]};
    return bcd ? (hi * 7'd10 + {3'b000, v[3:0]}) : v[6:0];
  endfunction

  // plain count -> register coding
  function automatic logic [7:0] from_bin(input logic [6:0] b, input logic bcd);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = b / 7'd10;
    ones = b % 7'd10;
    return bcd ? {tens[3:0], ones[3:0]} : {1'b0, b};
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] mo, input logic [6:0] yr);
    case (mo)
      7'd2:                     return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
      default:                  return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_host_port.sv
module rtc_host_port #(
  parameter int IDX_W = 7,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_sel_data,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    rd_value,
  output logic [IDX_W-1:0] index_q,
  output logic             data_wr,
  output logic             data_rd,
  output logic [DW-1:0]    rdata_q
);
  assign data_wr = bus_wr & bus_sel_data;
  assign data_rd = bus_rd & bus_sel_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_wr && !bus_sel_data)
        index_q <= bus_wdata[IDX_W-1:0];
      if (bus_rd)
        rdata_q <= bus_sel_data ? rd_value : '0;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             freeze,
  input  logic             bcd,
  input  logic             h24,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output rtc_time_t        time_q
);
  rtc_time_t  nxt;
  logic [6:0] s_b, m_b, h_b, wd_b, md_b, mo_b, yr_b, dim, nh;
  logic       pm, npm, c_min, c_hr, c_day, c_mon, c_yr;
  logic [7:0] nh_code;
  logic       advance;

  assign advance = tick & ~freeze;

  always_comb begin
    s_b  = to_bin(time_q.sec, bcd);
    m_b  = to_bin(time_q.minute, bcd);
    h_b  = to_bin({1'b0, time_q.hour[6:0]}, bcd);
    wd_b = to_bin(time_q.wday, bcd);
    md_b = to_bin(time_q.mday, bcd);
    mo_b = to_bin(time_q.mon, bcd);
    yr_b = to_bin(time_q.year, bcd);
    dim  = month_len(mo_b, yr_b);
    pm   = time_q.hour[7];
    nxt  = time_q;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
    nh = h_b; npm = pm; nh_code = '0;

    if (s_b >= 7'd59) begin
      nxt.sec = from_bin(7'd0, bcd);
      c_min = 1'b1;
    end else nxt.sec = from_bin(s_b + 7'd1, bcd);

    if (c_min) begin
      if (m_b >= 7'd59) begin
        nxt.minute = from_bin(7'd0, bcd);
        c_hr = 1'b1;
      end else nxt.minute = from_bin(m_b + 7'd1, bcd);
    end

    if (c_hr) begin
      if (h24) begin
        if (h_b >= 7'd23) begin
          nh = 7'd0;
          c_day = 1'b1;
        end else nh = h_b + 7'd1;
        nxt.hour = from_bin(nh, bcd);
      end else begin
        if (h_b == 7'd11) begin
          nh = 7'd12;
          npm = ~pm;
          c_day = pm;
        end else if (h_b >= 7'd12) nh = 7'd1;
        else nh = h_b + 7'd1;
        nh_code = from_bin(nh, bcd);
        nxt.hour = {npm, nh_code[6:0]};
      end
    end

    if (c_day) begin
      nxt.wday = (wd_b >= 7'd7) ? from_bin(7'd1, bcd) : from_bin(wd_b + 7'd1, bcd);
      if (md_b >= dim) begin
        nxt.mday = from_bin(7'd1, bcd);
        c_mon = 1'b1;
      end else nxt.mday = from_bin(md_b + 7'd1, bcd);
    end

    if (c_mon) begin
      if (mo_b >= 7'd12) begin
        nxt.mon = from_bin(7'd1, bcd);
        c_yr = 1'b1;
      end else nxt.mon = from_bin(mo_b + 7'd1, bcd);
    end

    if (c_yr)
      nxt.year = (yr_b >= 7'd99) ? from_bin(7'd0, bcd) : from_bin(yr_b + 7'd1, bcd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q <= TIME_RESET;
    end else begin
      if (advance) time_q <= nxt;
      if (wr_en) begin
        case (wr_idx)
          IDX_W'(IDX_SEC):  time_q.sec    <= wr_data;
          IDX_W'(IDX_MIN):  time_q.minute <= wr_data;
          IDX_W'(IDX_HOUR): time_q.hour   <= wr_data;
          IDX_W'(IDX_WDAY): time_q.wday   <= wr_data;
          IDX_W'(IDX_MDAY): time_q.mday   <= wr_data;
          IDX_W'(IDX_MON):  time_q.mon    <= wr_data;
          IDX_W'(IDX_YEAR): time_q.year   <= wr_data;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_power_flag.sv
module rtc_power_flag (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic rd_strobe,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)             flag_q <= 1'b1;
    else if (!supply_ok) flag_q <= 1'b0;
    else if (rd_strobe)  flag_q <= 1'b1;
  end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sec_tick,
  input  logic       supply_ok,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_sel_data,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  logic [IDX_W-1:0]  index_q;
  logic              data_wr, data_rd;
  logic [RTC_DW-1:0] ctrl_q, rd_value;
  rtc_time_t         time_q;
  logic              pwr_flag;
  logic              stat_rd;

  rtc_host_port #(.IDX_W(IDX_W), .DW(RTC_DW)) u_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel_data(bus_sel_data), .bus_wdata(bus_wdata), .rd_value(rd_value),
    .index_q(index_q), .data_wr(data_wr), .data_rd(data_rd), .rdata_q(bus_rdata)
  );

  rtc_calendar #(.IDX_W(IDX_W)) u_cal (
    .clk(clk), .rst(rst), .tick(sec_tick),
    .freeze(ctrl_q[CTRL_FREEZE]), .bcd(~ctrl_q[CTRL_BIN]), .h24(ctrl_q[CTRL_H24]),
    .wr_en(data_wr), .wr_idx(index_q), .wr_data(bus_wdata), .time_q(time_q)
  );

  assign stat_rd = data_rd && (index_q == IDX_W'(IDX_STAT));

  rtc_power_flag u_pwr (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .rd_strobe(stat_rd), .flag_q(pwr_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= CTRL_RESET;
    else if (data_wr && index_q == IDX_W'(IDX_CTRL)) ctrl_q <= bus_wdata & CTRL_MASK;
  end

  always_comb begin
    case (index_q)
      IDX_W'(IDX_SEC):  rd_value = time_q.sec;
      IDX_W'(IDX_MIN):  rd_value = time_q.minute;
      IDX_W'(IDX_HOUR): rd_value = time_q.hour;
      IDX_W'(IDX_WDAY): rd_value = time_q.wday;
      IDX_W'(IDX_MDAY): rd_value = time_q.mday;
      IDX_W'(IDX_MON):  rd_value = time_q.mon;
      IDX_W'(IDX_YEAR): rd_value = time_q.year;
      IDX_W'(IDX_CTRL): rd_value = ctrl_q;
      IDX_W'(IDX_STAT): rd_value = {pwr_flag, 7'b0};
      default:          rd_value = '0;
    endcase
  end
endmodule

// File: rtl/rtc_timekeeper_chk.sv
module rtc_timekeeper_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             sec_tick,
  input logic             supply_ok,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             bus_sel_data,
  input logic [7:0]       bus_rdata,
  input logic [IDX_W-1:0] index_q,
  input logic             frozen,
  input logic [7:0]       sec_q,
  input logic             pwr_flag
);
  logic host_data_wr, host_data_rd, unimpl;
  assign host_data_wr = bus_wr && bus_sel_data;
  assign host_data_rd = bus_rd && bus_sel_data;

  always_comb begin
    unimpl = 1'b1;
    if (index_q == IDX_W'(0) || index_q == IDX_W'(2) || index_q == IDX_W'(4) ||
        index_q == IDX_W'(6) || index_q == IDX_W'(7) || index_q == IDX_W'(8) ||
        index_q == IDX_W'(9) || index_q == IDX_W'(11) || index_q == IDX_W'(13))
      unimpl = 1'b0;
  end

  assert_frozen_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (frozen && !host_data_wr) |=> $stable(sec_q));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!sec_tick && !host_data_wr) |=> $stable(sec_q));

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  assert_supply_drop_R10: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !pwr_flag);

  assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (host_data_rd && unimpl) |=> (bus_rdata == 8'h00));

  assert_ctrl_mask_R11: assert property (@(posedge clk) disable iff (rst)
    (host_data_rd && index_q == IDX_W'(11)) |=> ((bus_rdata & 8'h79) == 8'h00));
endmodule

bind rtc_timekeeper rtc_timekeeper_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .supply_ok(supply_ok),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel_data(bus_sel_data),
  .bus_rdata(bus_rdata), .index_q(index_q), .frozen(ctrl_q[7]),
  .sec_q(time_q.sec), .pwr_flag(pwr_flag)
);

// File: tb/rtc_timekeeper_tb.sv
module rtc_timekeeper_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0;
  logic supply_ok = 1'b1;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic bus_sel_data = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  rtc_timekeeper u_dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .supply_ok(supply_ok),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel_data(bus_sel_data),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr_index(input logic [7:0] i);
    @(negedge clk); bus_wr = 1'b1; bus_sel_data = 1'b0; bus_wdata = i;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    wr_index(i);
    @(negedge clk); bus_wr = 1'b1; bus_sel_data = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] v);
    wr_index(i);
    @(negedge clk); bus_rd = 1'b1; bus_sel_data = 1'b1;
    @(negedge clk); v = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] i, input logic [7:0] exp);
    logic [7:0] v;
    rd_reg(i, v);
    check(req, v, exp);
  endtask

  task automatic one_tick;
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                         input logic [7:0] wd, input logic [7:0] md,
                         input logic [7:0] mo, input logic [7:0] yr);
    wr_reg(8'd0, s); wr_reg(8'd2, m); wr_reg(8'd4, h);
    wr_reg(8'd6, wd); wr_reg(8'd7, md); wr_reg(8'd8, mo); wr_reg(8'd9, yr);
  endtask

  task automatic t_reset_r1;
    expect_reg("R1 sec", 8'd0, 8'h00);
    expect_reg("R1 min", 8'd2, 8'h00);
    expect_reg("R1 hour", 8'd4, 8'h00);
    expect_reg("R1 wday", 8'd6, 8'h01);
    expect_reg("R1 mday", 8'd7, 8'h01);
    expect_reg("R1 mon", 8'd8, 8'h01);
    expect_reg("R1 year", 8'd9, 8'h00);
    expect_reg("R1 ctrl", 8'd11, 8'h02);
    expect_reg("R1 stat", 8'd13, 8'h80);
  endtask

  task automatic t_access_r2;
    wr_reg(8'h82, 8'h45);             // index bit 7 dropped -> minutes
    expect_reg("R2 index bit7 ignored", 8'd2, 8'h45);
    repeat (3) @(negedge clk);
    check("R2 rdata held", bus_rdata, 8'h45);
  endtask

  task automatic t_format_r4;
    wr_reg(8'd11, 8'h02);
    set_all(8'h10, 8'h00, 8'h09, 8'h01, 8'h01, 8'h01, 8'h00);
    one_tick;
    expect_reg("R4 BCD 09->10", 8'd0, 8'h10);
    wr_reg(8'd11, 8'h06);
    wr_reg(8'd0, 8'h09);
    one_tick;
    expect_reg("R4 binary 9->10", 8'd0, 8'h0A);
    wr_reg(8'd0, 8'd59); wr_reg(8'd2, 8'd7);
    one_tick;
    expect_reg("R3 binary sec wrap", 8'd0, 8'h00);
    expect_reg("R3 binary min carry", 8'd2, 8'd8);
    wr_reg(8'd11, 8'h02);
  endtask

  task automatic t_day_r3;
    set_all(8'h23, 8'h59, 8'h59, 8'h03, 8'h15, 8'h06, 8'h21);
    one_tick;
    expect_reg("R3 sec", 8'd0, 8'h00);
    expect_reg("R3 min", 8'd2, 8'h00);
    expect_reg("R3 hour 23->0", 8'd4, 8'h00);
    expect_reg("R6 wday step", 8'd6, 8'h04);
    expect_reg("R7 mday step", 8'd7, 8'h16);
    expect_reg("R7 mon hold", 8'd8, 8'h06);
  endtask

  task automatic t_twelve_r5;
    wr_reg(8'd11, 8'h00);
    set_all(8'h11, 8'h59, 8'h59, 8'h02, 8'h10, 8'h03, 8'h22);
    one_tick;
    expect_reg("R5 11AM->12PM", 8'd4, 8'h92);
    expect_reg("R5 no day carry at noon", 8'd7, 8'h10);
    wr_reg(8'd2, 8'h59); wr_reg(8'd0, 8'h59);
    one_tick;
    expect_reg("R5 12PM->1PM", 8'd4, 8'h81);
    set_all(8'h91, 8'h59, 8'h59, 8'h02, 8'h10, 8'h03, 8'h22);
    one_tick;
    expect_reg("R5 11PM->12AM", 8'd4, 8'h12);
    expect_reg("R5 midnight day carry", 8'd7, 8'h11);
    wr_reg(8'd11, 8'h02);
  endtask

  task automatic t_week_r6;
    set_all(8'h23, 8'h59, 8'h59, 8'h07, 8'h05, 8'h05, 8'h22);
    one_tick;
    expect_reg("R6 wday 7->1", 8'd6, 8'h01);
  endtask

  task automatic t_month_r7;
    set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h04, 8'h22);
    one_tick;
    expect_reg("R7 30-day month end", 8'd7, 8'h01);
    expect_reg("R7 month carry", 8'd8, 8'h05);
    set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h01, 8'h22);
    one_tick;
    expect_reg("R7 31-day month 30->31", 8'd7, 8'h31);
    set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h23);
    one_tick;
    expect_reg("R7 Feb non-leap end", 8'd7, 8'h01);
    expect_reg("R7 Feb non-leap month", 8'd8, 8'h03);
    set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h24);
    one_tick;
    expect_reg("R7 Feb leap 28->29", 8'd7, 8'h29);
    set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h31, 8'h12, 8'h99);
    one_tick;
    expect_reg("R7 year-end mday", 8'd7, 8'h01);
    expect_reg("R7 year-end month", 8'd8, 8'h01);
    expect_reg("R7 year 99->00", 8'd9, 8'h00);
  endtask

  task automatic t_freeze_r8;
    wr_reg(8'd11, 8'h82);
    wr_reg(8'd0, 8'h10);
    one_tick; one_tick;
    expect_reg("R8 frozen", 8'd0, 8'h10);
    wr_reg(8'd11, 8'h02);
    one_tick;
    expect_reg("R8 resumed", 8'd0, 8'h11);
  endtask

  task automatic t_unimpl_r9;
    wr_reg(8'h20, 8'h55);
    expect_reg("R9 idx 0x20", 8'h20, 8'h00);
    wr_reg(8'd1, 8'hAA);
    expect_reg("R9 idx 1", 8'd1, 8'h00);
    expect_reg("R9 idx 10", 8'd10, 8'h00);
  endtask

  task automatic t_power_r10;
    wr_reg(8'd13, 8'h00);
    expect_reg("R10 write ignored", 8'd13, 8'h80);
    @(negedge clk); supply_ok = 1'b0;
    @(negedge clk); supply_ok = 1'b1;
    repeat (2) @(negedge clk);
    expect_reg("R10 flag cleared", 8'd13, 8'h00);
    expect_reg("R10 flag re-armed", 8'd13, 8'h80);
  endtask

  task automatic t_ctrl_r11;
    wr_reg(8'd11, 8'hFF);
    expect_reg("R11 ctrl mask", 8'd11, 8'h86);
    wr_reg(8'd11, 8'h02);
  endtask

  task automatic t_collide_r12;
    wr_reg(8'd0, 8'h20);
    @(negedge clk); bus_wr = 1'b1; bus_sel_data = 1'b1; bus_wdata = 8'h33; sec_tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; sec_tick = 1'b0;
    expect_reg("R12 write wins over tick", 8'd0, 8'h33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_r1;
    t_access_r2;
    t_format_r4;
    t_day_r3;
    t_twelve_r5;
    t_week_r6;
    t_month_r7;
    t_freeze_r8;
    t_unimpl_r9;
    t_power_r10;
    t_ctrl_r11;
    t_collide_r12;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule